// File: doc/BRIEF.md
# Parallel Concatenated Convolutional Encoder

This block turns a block of `BLK_LEN` information bits into a rate-about-one-third coded bit stream. It uses two identical recursive systematic convolutional encoders. Input bits arrive one per handshake on a valid/ready stream and are held in a local buffer until the whole block is present. Encoding then begins. The first encoder walks the buffer in natural order. The second encoder walks it through a permutation table, so at step k it consumes `buf[perm[k]]` while the first consumes `buf[k]`.

The output is a serial bit stream with valid/ready flow control and first/last markers. For each index k it carries three bits: the systematic bit, the parity of the first encoder, and the parity of the second encoder. The second encoder's own systematic bit is never sent. After the 3·L data bits, the first encoder is driven back to the all-zero state and its termination group follows. The second encoder's termination group comes after that. Each group holds 2·`MEM` bits. With the defaults (L = 64, eight states) a block produces 204 output bits.

The permutation table is loaded through a simple write port while the block is idle. Indices are zero-based. After reset the table holds the order-reversing mapping.

Top module: `turbo_enc`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` stays 1 until exactly `BLK_LEN` bits have been accepted. It is then 0 from the next cycle until the handshake of the final output bit. After that handshake `in_ready` is 1 again and `out_valid` is 0.
- R3: Output bits 3k and 3k+1 (k = 0..L-1) are the systematic bit `d[k]` and the parity of encoder one. Encoder one has feedback taps on delays 2 and 3 (a = u ^ s2 ^ s3) and parity z = a ^ s1 ^ s3. Its shift register is s1 <= a, s2 <= s1, s3 <= s2.
- R4: Output bit 3k+2 is the parity of encoder two. Encoder two has the same code as encoder one and is fed with `d[perm[k]]`.
- R5: The bits after the 3·L data bits form two groups of 2·MEM bits each: encoder one's group first, then encoder two's group. Each group is MEM pairs (u, z), where u = s2 ^ s3 forces a = 0. The total length is 3·L + 4·MEM (204 by default).
- R6: `out_first` is 1 only with the first output bit of a block. `out_last` is 1 only with the final bit.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_bit`, `out_first` and `out_last` hold their values.
- R8: After reset the permutation is perm[k] = L-1-k.
- R9: A write with `cfg_we` = 1 sets perm[`cfg_addr`] = `cfg_idx` (zero-based) only while `in_ready` is 1. A write made while encoding has no effect.
- R10: Both encoder states are zero at the start of every block, whatever the previous block left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Permutation table write strobe |
| cfg_addr | input | $clog2(BLK_LEN) | Table entry to write |
| cfg_idx | input | $clog2(BLK_LEN) | Zero-based source index for that entry |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block accepts an input bit |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Coded bit |
| out_first | output | 1 | Marks the first coded bit of a block |
| out_last | output | 1 | Marks the last coded bit of a block |

## Verification
The hardest condition to reach from the ports is a table write that arrives in the middle of encoding. It has to be shown to leave no trace, and that can only be seen through the parity of a later block. The bench issues random writes while the output drains. It then encodes a fresh random block against the previously loaded permutation and compares every bit. Random stalls on `out_ready` land on data bits, on tail bits and on the group boundary. Consecutive blocks with differing data show that no encoder state leaks across a block.

// File: rtl/turbo_pkg.sv
package turbo_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_DATA  = 2'd1,
    ST_TAIL1 = 2'd2,
    ST_TAIL2 = 2'd3
  } enc_phase_t;
endpackage

// File: rtl/rsc_enc.sv
module rsc_enc #(
  parameter int          MEM     = 3,
  parameter logic [MEM:0] FB_POLY = 4'b1011,
  parameter logic [MEM:0] FF_POLY = 4'b1101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic term,
  input  logic u_in,
  output logic u_eff,
  output logic parity
);
  function automatic logic [MEM-1:0] taps(input logic [MEM:0] p);
    logic [MEM-1:0] m;
    for (int i = 0; i < MEM; i++) m[i] = p[MEM-1-i];
    return m;
  endfunction

  localparam logic [MEM-1:0] FB_MASK = taps(FB_POLY);
  localparam logic [MEM-1:0] FF_MASK = taps(FF_POLY);

  logic [MEM-1:0] sreg, sreg_n;
  logic           fb_sum, a_bit;

  always_comb begin
    fb_sum = ^(sreg & FB_MASK);
    u_eff  = term ? fb_sum : u_in;
    a_bit  = u_eff ^ fb_sum;
    parity = (FF_POLY[MEM] & a_bit) ^ (^(sreg & FF_MASK));
    sreg_n = sreg;
    if (clr)       sreg_n = '0;
    else if (step) sreg_n = {sreg[MEM-2:0], a_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '0;
    else        sreg <= sreg_n;
  end
endmodule

// File: rtl/perm_table.sv
module perm_table #(
  parameter int BLK_LEN = 64,
  localparam int AW     = $clog2(BLK_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] tbl [BLK_LEN];

  for (genvar i = 0; i < BLK_LEN; i++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tbl[i] <= AW'(BLK_LEN - 1 - i);
      else if (hit) tbl[i] <= wdata;
    end
  end

  assign rdata = tbl[raddr];
endmodule

// File: rtl/bit_buffer.sv
module bit_buffer #(
  parameter int BLK_LEN = 64,
  localparam int AW     = $clog2(BLK_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic          rbit_a,
  output logic          rbit_b
);
  logic [BLK_LEN-1:0] mem_q, mem_n;

  always_comb begin
    mem_n = mem_q;
    if (we) mem_n[waddr] = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_n;
  end

  assign rbit_a = mem_q[raddr_a];
  assign rbit_b = mem_q[raddr_b];
endmodule

// File: rtl/turbo_enc.sv
module turbo_enc
  import turbo_pkg::*;
#(
  parameter int BLK_LEN = 64,
  parameter int MEM     = 3,
  localparam int AW     = $clog2(BLK_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_idx,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          out_first,
  output logic          out_last
);
  localparam int            TW       = $clog2(2 * MEM);
  localparam logic [AW-1:0] LAST_IDX = AW'(BLK_LEN - 1);
  localparam logic [TW-1:0] LAST_T   = TW'(2 * MEM - 1);

  enc_phase_t    st_q, st_n;
  logic [AW-1:0] idx_q, idx_n;
  logic [1:0]    sub_q, sub_n;
  logic [TW-1:0] tc_q, tc_n;

  logic          fire, acc, enc_clr;
  logic          step1, step2;
  logic [AW-1:0] pidx;
  logic          d_nat, d_prm;
  logic          u1, z1, u2, z2;

  assign in_ready  = (st_q == ST_LOAD);
  assign out_valid = (st_q != ST_LOAD);
  assign acc       = in_valid && in_ready;
  assign fire      = out_valid && out_ready;

  perm_table #(.BLK_LEN(BLK_LEN)) u_perm (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we && in_ready), .waddr(cfg_addr), .wdata(cfg_idx),
    .raddr(idx_q), .rdata(pidx)
  );

  bit_buffer #(.BLK_LEN(BLK_LEN)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .we(acc), .waddr(idx_q), .wbit(in_bit),
    .raddr_a(idx_q), .raddr_b(pidx),
    .rbit_a(d_nat), .rbit_b(d_prm)
  );

  rsc_enc #(.MEM(MEM)) u_enc1 (
    .clk(clk), .rst_n(rst_n), .clr(enc_clr), .step(step1),
    .term(st_q == ST_TAIL1), .u_in(d_nat), .u_eff(u1), .parity(z1)
  );

  rsc_enc #(.MEM(MEM)) u_enc2 (
    .clk(clk), .rst_n(rst_n), .clr(enc_clr), .step(step2),
    .term(st_q == ST_TAIL2), .u_in(d_prm), .u_eff(u2), .parity(z2)
  );

  // output selection
  always_comb begin
    out_bit = 1'b0;
    unique case (st_q)
      ST_DATA:  out_bit = (sub_q == 2'd0) ? d_nat : (sub_q == 2'd1) ? z1 : z2;
      ST_TAIL1: out_bit = tc_q[0] ? z1 : u1;
      ST_TAIL2: out_bit = tc_q[0] ? z2 : u2;
      default:  out_bit = 1'b0;
    endcase
  end

  assign out_first = (st_q == ST_DATA) && (idx_q == '0) && (sub_q == 2'd0);
  assign out_last  = (st_q == ST_TAIL2) && (tc_q == LAST_T);

  // next-state logic
  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    sub_n   = sub_q;
    tc_n    = tc_q;
    enc_clr = 1'b0;
    step1   = 1'b0;
    step2   = 1'b0;
    unique case (st_q)
      ST_LOAD: if (acc) begin
        if (idx_q == LAST_IDX) begin
          st_n    = ST_DATA;
          idx_n   = '0;
          sub_n   = 2'd0;
          enc_clr = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_DATA: if (fire) begin
        step1 = (sub_q == 2'd1);
        step2 = (sub_q == 2'd2);
        if (sub_q == 2'd2) begin
          sub_n = 2'd0;
          if (idx_q == LAST_IDX) begin
            st_n = ST_TAIL1;
            tc_n = '0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end else begin
          sub_n = sub_q + 1'b1;
        end
      end
      ST_TAIL1: if (fire) begin
        step1 = tc_q[0];
        if (tc_q == LAST_T) begin
          st_n = ST_TAIL2;
          tc_n = '0;
        end else begin
          tc_n = tc_q + 1'b1;
        end
      end
      ST_TAIL2: if (fire) begin
        step2 = tc_q[0];
        if (tc_q == LAST_T) begin
          st_n  = ST_LOAD;
          idx_n = '0;
          tc_n  = '0;
        end else begin
          tc_n = tc_q + 1'b1;
        end
      end
      default: st_n = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOAD;
      idx_q <= '0;
      sub_q <= 2'd0;
      tc_q  <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      sub_q <= sub_n;
      tc_q  <= tc_n;
    end
  end
endmodule

// File: rtl/turbo_enc_chk.sv
module turbo_enc_chk #(
  parameter int BLK_LEN = 64,
  parameter int MEM     = 3
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_first,
  input logic out_last
);
  localparam int NOUT = 3 * BLK_LEN + 4 * MEM;

  logic [15:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      beats <= '0;
    else if (out_valid && out_ready) beats <= out_last ? '0 : beats + 16'd1;
  end

  p_busy_blocks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_idle_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_bit) && $stable(out_first) && $stable(out_last)));

  p_first_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> (beats == 16'd0));

  p_last_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (beats == 16'(NOUT - 1)));

  p_flags_need_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first || out_last) |-> out_valid);
endmodule

bind turbo_enc turbo_enc_chk #(.BLK_LEN(BLK_LEN), .MEM(MEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .out_first(out_first),
  .out_last(out_last)
);

// File: tb/tb_turbo_enc.sv
module tb_turbo_enc;
  localparam int L  = 64;
  localparam int AW = 6;
  localparam int N  = 3 * L + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0, cfg_idx = '0;
  logic          in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid, out_bit, out_first, out_last;

  int checks = 0, errors = 0;
  bit data[L];
  int perm[L];
  bit expv[N];

  always #4 clk = ~clk;

  turbo_enc #(.BLK_LEN(L), .MEM(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_idx(cfg_idx), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_first(out_first), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference code: a = u^s2^s3, z = a^s1^s3
  task automatic model();
    bit s1, s2, s3, t1, t2, t3, a, u;
    s1 = 0; s2 = 0; s3 = 0; t1 = 0; t2 = 0; t3 = 0;
    for (int k = 0; k < L; k++) begin
      expv[3*k] = data[k];
      a = data[k] ^ s2 ^ s3;
      expv[3*k+1] = a ^ s1 ^ s3;
      s3 = s2; s2 = s1; s1 = a;
      a = data[perm[k]] ^ t2 ^ t3;
      expv[3*k+2] = a ^ t1 ^ t3;
      t3 = t2; t2 = t1; t1 = a;
    end
    for (int t = 0; t < 3; t++) begin
      u = s2 ^ s3;
      expv[3*L+2*t] = u;
      expv[3*L+2*t+1] = s1 ^ s3;
      s3 = s2; s2 = s1; s1 = 1'b0;
    end
    for (int t = 0; t < 3; t++) begin
      u = t2 ^ t3;
      expv[3*L+6+2*t] = u;
      expv[3*L+6+2*t+1] = t1 ^ t3;
      t3 = t2; t2 = t1; t1 = 1'b0;
    end
  endtask

  task automatic load_perm();
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(i); cfg_idx = AW'(perm[i]);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_block(input bit stall, input bit garble);
    int  k, j, guard;
    bit  acc, rdy, prev_stall, prev_bit, prev_first, prev_last, ir_bad;
    bit  got[N];
    bit  gf[N];
    bit  gl[N];
    model();
    k = 0; guard = 0;
    while (k < L && guard < 2000) begin
      @(negedge clk);
      in_bit   = data[k];
      in_valid = ($urandom % 4) != 0;
      acc      = in_valid && in_ready;
      if (acc) k++;
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 in_ready low after block", int'(in_ready), 0);
    check(out_valid == 1'b1, "R2 encoding starts", int'(out_valid), 1);
    j = 0; guard = 0; prev_stall = 0; ir_bad = 0;
    prev_bit = 0; prev_first = 0; prev_last = 0;
    while (j < N && guard < 5000) begin
      if (guard != 0) @(negedge clk);
      guard++;
      if (in_ready) ir_bad = 1;
      if (prev_stall)
        check(out_bit == prev_bit && out_first == prev_first && out_last == prev_last,
              "R7 hold on stall", int'(out_bit), int'(prev_bit));
      rdy = stall ? (($urandom % 3) != 0) : 1'b1;
      out_ready = rdy;
      cfg_we    = garble && (($urandom % 2) != 0) && !(rdy && out_last);
      cfg_addr  = AW'($urandom);
      cfg_idx   = AW'($urandom);
      if (out_valid) begin
        got[j] = out_bit; gf[j] = out_first; gl[j] = out_last;
        if (rdy) j++;
      end
      prev_stall = out_valid && !rdy;
      prev_bit = out_bit; prev_first = out_first; prev_last = out_last;
    end
    @(negedge clk);
    out_ready = 1'b0; cfg_we = 1'b0;
    check(!ir_bad, "R2 in_ready low while encoding", int'(ir_bad), 0);
    check(j == N, "R5 output length", j, N);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R2 idle after last bit",
          int'(in_ready), 1);
    for (int i = 0; i < N; i++) begin
      if (i < 3 * L && i % 3 != 2)
        check(got[i] == expv[i], "R3 data bit", int'(got[i]), int'(expv[i]));
      else if (i < 3 * L)
        check(got[i] == expv[i], "R4 interleaved parity", int'(got[i]), int'(expv[i]));
      else
        check(got[i] == expv[i], "R5 tail bit", int'(got[i]), int'(expv[i]));
      check(gf[i] == (i == 0), "R6 first flag", int'(gf[i]), int'(i == 0));
      check(gl[i] == (i == N - 1), "R6 last flag", int'(gl[i]), int'(i == N - 1));
    end
  endtask

  initial begin
    #(100000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;

    // R8: default reversal table, random data, random stalls
    for (int i = 0; i < L; i++) begin perm[i] = L - 1 - i; data[i] = bit'($urandom); end
    run_block(1'b1, 1'b0);

    // R9: load a random permutation, then encode
    for (int i = 0; i < L; i++) perm[i] = i;
    for (int i = L - 1; i > 0; i--) begin
      int r, tmp;
      r = int'($urandom % (i + 1));
      tmp = perm[i]; perm[i] = perm[r]; perm[r] = tmp;
    end
    load_perm();
    for (int i = 0; i < L; i++) data[i] = bit'($urandom);
    run_block(1'b1, 1'b0);

    // R9: garbage writes during encoding must be ignored (seen in the next block)
    for (int i = 0; i < L; i++) data[i] = bit'($urandom);
    run_block(1'b0, 1'b1);
    for (int i = 0; i < L; i++) data[i] = bit'($urandom);
    run_block(1'b1, 1'b0);

    // R10: directed all-ones then all-zeros; states must restart from zero
    for (int i = 0; i < L; i++) data[i] = 1'b1;
    run_block(1'b0, 1'b0);
    for (int i = 0; i < L; i++) data[i] = 1'b0;
    run_block(1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule